// File: doc/BRIEF.md
# Interrupt Gate with Privileged Shadow

This block sits between the interrupt request logic and the instruction sequencer of a processor core. At every instruction boundary it decides whether a pending interrupt may be taken, and signals acceptance with a single-cycle pulse. The decode stage flags each instruction that must run atomically with its successor. Examples are a stack-pointer load that must be followed by a stack-segment load, a write to the interrupt-priority register that must be followed by a return, a code-segment load from the accumulator, and a memory bit test used as the first half of a test-then-set semaphore. For such an instruction the gate refuses the interrupt at the boundary that closes it. The next instruction therefore runs before any interrupt can intervene.

The privilege flag may arrive in any cycle of the instruction it belongs to, including the boundary cycle. It is remembered until that instruction's boundary and then discarded. The parameter `SHIELD_INSNS` sets how many following instructions are shielded, with a default of one. When it is larger, a down-counter blocks that many extra boundaries beyond the default. The parameter `ACCEPT_REG` selects between a registered accept pulse (default, one cycle after the boundary) and a combinational pulse in the boundary cycle. Priority arbitration, vector generation and opcode classification are outside this block.

Top module: `irq_shadow_gate`

## Requirements
- R1: `irq_accept` is high only in the cycle directly after a cycle in which `insn_done` and `irq_pending` were both high (default registered accept).
- R2: At a boundary that closes an instruction during which `insn_priv` was high in any cycle, including the boundary cycle itself, no accept follows.
- R3: With the default shield of one instruction, a boundary with `irq_pending` high that closes a non-privileged instruction is accepted, even when the previous instruction was privileged.
- R4: Consecutive privileged instructions each block their own boundary, so the shadow extends by one instruction per privileged instruction. The first non-privileged instruction after them is accepted.
- R5: Reset (`rst_n` low, asynchronous) holds `irq_accept` at 0 and discards any privilege flag already seen for the instruction in progress.
- R6: An accept is a single-cycle pulse. In the cycle after an accept that was not followed by another boundary, `irq_accept` is 0.
- R7: A boundary with `irq_pending` low produces no accept, whatever the shadow state.
- R8: A privilege flag raised before the boundary cycle of its instruction is held until that boundary, and has no effect on the boundary after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pending | input | 1 | An interrupt request awaits acceptance |
| insn_done | input | 1 | One-cycle strobe marking the last cycle of an instruction |
| insn_priv | input | 1 | Decode flags the current instruction as privileged |
| irq_accept | output | 1 | One-cycle pulse granting the pending interrupt |

## Verification
The assertions assume that `insn_done` is high for exactly one cycle per instruction, and that `insn_priv` always refers to the instruction that has not yet reached its boundary. They also assume that no boundary falls while reset is asserted. The stimulus keeps to these rules. It drives whole instructions of one to four cycles from a task. Inputs change only on the falling edge, `irq_pending` is held for the duration of each instruction, and the privilege flag is pulsed in a single chosen cycle of its own instruction. Boundaries are raised only after reset has been released.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   // Boundary event handed from the gating logic to the accept stage
   typedef struct packed {
      logic boundary;
      logic pending;
      logic shielded;
   } gate_evt_t;

   // Counter width able to hold values up to n-1, never narrower than one bit
   function automatic int shadow_cnt_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/priv_mark_latch.sv
module priv_mark_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic insn_done,
   input  logic priv_flag,
   output logic cur_priv
);

   logic mark_q;

   // Sticky per-instruction record, wiped at each boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_q <= 1'b0;
      end else if (insn_done) begin
         mark_q <= 1'b0;
      end else if (priv_flag) begin
         mark_q <= 1'b1;
      end
   end

   assign cur_priv = mark_q | priv_flag;

   // R8
   mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_flag && !insn_done) |=> cur_priv);

   // R8
   mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && !priv_flag) |=> (cur_priv == priv_flag));

endmodule

// File: rtl/shadow_tracker.sv
module shadow_tracker #(
   parameter int SHIELD_INSNS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic insn_done,
   input  logic cur_priv,
   output logic shielded
);

   localparam int CNT_W = irq_gate_pkg::shadow_cnt_w(SHIELD_INSNS);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SHIELD_INSNS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             cnt_busy;

   assign cnt_busy = (cnt_q != '0);
   assign shielded = cur_priv | cnt_busy;

   // Extra boundaries to block after the one closing a privileged instruction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (insn_done) begin
         if (cur_priv) begin
            cnt_q <= RELOAD;
         end else if (cnt_busy) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD);

endmodule

// File: rtl/accept_stage.sv
module accept_stage #(
   parameter int ACCEPT_REG = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  irq_gate_pkg::gate_evt_t evt,
   output logic                    irq_accept
);

   logic grant;

   assign grant = evt.boundary & evt.pending & ~evt.shielded;

   if (ACCEPT_REG != 0) begin : g_reg
      logic acc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= 1'b0;
         end else begin
            acc_q <= grant;
         end
      end

      assign irq_accept = acc_q;

      // R1
      acc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_accept |-> $past(evt.boundary && evt.pending));

      // R7
      idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt.boundary && !evt.pending) |=> !irq_accept);

      // R2
      shield_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt.boundary && evt.shielded) |=> !irq_accept);
   end else begin : g_comb
      assign irq_accept = grant;

      // R1
      acc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_accept |-> (evt.boundary && evt.pending && !evt.shielded));
   end

endmodule

// File: rtl/irq_shadow_gate.sv
module irq_shadow_gate #(
   parameter int SHIELD_INSNS = 1,
   parameter int ACCEPT_REG   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_pending,
   input  logic insn_done,
   input  logic insn_priv,
   output logic irq_accept
);

   import irq_gate_pkg::*;

   if (SHIELD_INSNS < 1) begin : g_bad_shield
      $error("SHIELD_INSNS must be at least 1");
   end
   if (ACCEPT_REG < 0 || ACCEPT_REG > 1) begin : g_bad_acc
      $error("ACCEPT_REG must be 0 or 1");
   end

   logic      cur_priv;
   logic      shielded;
   gate_evt_t evt;

   priv_mark_latch u_mark (
      .clk       (clk),
      .rst_n     (rst_n),
      .insn_done (insn_done),
      .priv_flag (insn_priv),
      .cur_priv  (cur_priv)
   );

   shadow_tracker #(.SHIELD_INSNS(SHIELD_INSNS)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .insn_done (insn_done),
      .cur_priv  (cur_priv),
      .shielded  (shielded)
   );

   assign evt.boundary = insn_done;
   assign evt.pending  = irq_pending;
   assign evt.shielded = shielded;

   accept_stage #(.ACCEPT_REG(ACCEPT_REG)) u_accept (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .irq_accept (irq_accept)
   );

endmodule

// File: tb/irq_shadow_gate_tb.sv
`timescale 1ns/1ps
module irq_shadow_gate_tb;

   localparam int SHIELD = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_pending = 1'b0;
   logic insn_done = 1'b0;
   logic insn_priv = 1'b0;
   logic irq_accept;

   int checks = 0;
   int errors = 0;
   int shadow_left = 0;
   logic bound_seen = 1'b0;
   bit last_acc = 1'b0;

   typedef struct {
      bit    exp;
      string req;
   } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;

   irq_shadow_gate u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_pending (irq_pending),
      .insn_done   (insn_done),
      .insn_priv   (insn_priv),
      .irq_accept  (irq_accept)
   );

   task automatic check(input bit got, input bit exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s irq_accept got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   // Driver: one instruction of len cycles, privilege pulsed at cycle priv_at
   task automatic run_insn(input int len, input int priv_at, input bit pend, input string req);
      bit is_priv;
      item_t it;
      is_priv = (priv_at >= 0) && (priv_at < len);
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         irq_pending = pend;
         insn_done   = (c == len - 1);
         insn_priv   = (c == priv_at);
         if (c == len - 1) begin
            it.exp = pend && !is_priv && (shadow_left == 0);
            it.req = req;
            sb_q.push_back(it);
            if (is_priv) shadow_left = SHIELD - 1;
            else if (shadow_left > 0) shadow_left--;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         insn_done = 1'b0;
         insn_priv = 1'b0;
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      insn_done = 1'b0;
      insn_priv = 1'b0;
      shadow_left = 0;
      repeat (3) @(negedge clk);
      check(irq_accept, 1'b0, "R5 reset");
      rst_n = 1'b1;
   endtask

   // Monitor
   always @(posedge clk) bound_seen <= insn_done && rst_n;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bound_seen) begin
            if (sb_q.size() == 0) begin
               errors++;
               $display("FAIL R1 scoreboard empty got %0b expected none", irq_accept);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               check(irq_accept, it.exp, it.req);
            end
            last_acc = irq_accept;
         end else begin
            if (last_acc) check(irq_accept, 1'b0, "R6 pulse width");
            else if (irq_accept) check(irq_accept, 1'b0, "R1 spurious");
            last_acc = 1'b0;
         end
      end else begin
         last_acc = 1'b0;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run hung got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      apply_reset();
      idle(2);
      run_insn(3, -1, 1'b1, "R1 plain accept");
      run_insn(2, -1, 1'b0, "R7 nothing pending");
      run_insn(1, -1, 1'b1, "R1 short insn");
      run_insn(1, -1, 1'b1, "R6 back to back boundaries");
      run_insn(3, 2, 1'b1, "R2 flag at boundary");
      run_insn(3, -1, 1'b1, "R3 shadow over");
      run_insn(4, 0, 1'b1, "R8 early flag held");
      run_insn(2, -1, 1'b1, "R8 flag forgotten");
      run_insn(2, 1, 1'b1, "R4 chain first");
      run_insn(1, 0, 1'b1, "R4 chain second");
      run_insn(3, 1, 1'b1, "R4 chain third");
      run_insn(2, -1, 1'b1, "R4 chain released");
      run_insn(2, 0, 1'b1, "R2 flag first cycle");
      run_insn(2, -1, 1'b0, "R7 shadow over but idle");
      run_insn(2, -1, 1'b1, "R3 accept after idle");
      run_insn(3, 1, 1'b0, "R7 privileged and idle");
      idle(3);
      // R5: flag seen mid-instruction, then reset discards it
      @(negedge clk);
      irq_pending = 1'b1;
      insn_priv   = 1'b1;
      @(negedge clk);
      insn_priv   = 1'b0;
      apply_reset();
      run_insn(2, -1, 1'b1, "R5 flag discarded by reset");
      for (int i = 0; i < 40; i++) begin
         int len;
         len = 1 + (i % 3);
         run_insn(len, ((i % 4) == 1) ? (i % len) : -1, (i % 5) != 0, "R3 mixed stream");
      end
      idle(4);
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R1 items left got %0d expected 0", sb_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule